// File: doc/BRIEF.md
# Path Remote Defect Indication Generator

This block chooses the remote-defect code that the transmitter places in bits 3 to 1 of the outgoing path status byte. It also raises a request for downstream alarm indication signal (AIS) insertion. Its inputs are the per-frame alarm levels that the receive side has already decided: loss of pointer, incoming AU-AIS, trace identifier mismatch, signal label mismatch, unequipped (the received signal label is all zeros) and loss of cell delineation. The block does not detect any of these conditions. Its outputs go straight to the transmit side of the same path, so the far end hears about local receive trouble.

Two coding conventions are available. The single-bit convention sets only the top bit of the field whenever any counted defect is present. The enhanced convention sorts defects into server, connectivity and payload classes and sends a distinct code for each class, with the server class taking priority. For "supervisory unequipped" operation, two separate bits take the unequipped alarm out of the RDI decision and out of the AIS decision. When the unequipped alarm no longer feeds AIS, a trace mismatch feeds it instead. Both outputs are registered. They change only on a frame-start strobe and hold their value between strobes.

Top module: `path_rdi_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first frame strobe, rdiCode is 3'b000 and aisReq is 0.
- R2: The outputs take new values only at a rising clock edge where frameStart is high. The new value is visible after that edge. At every other edge both outputs keep their value.
- R3: With enhancedMode low, rdiCode becomes 3'b100 when any counted defect is present at the strobe, and 3'b000 when none is present.
- R4: With enhancedMode high, loss of pointer or AU-AIS at the strobe gives rdiCode 3'b101, whatever other alarms are present.
- R5: With enhancedMode high and no server defect, a trace mismatch or a counted unequipped alarm gives rdiCode 3'b110.
- R6: With enhancedMode high, signal label mismatch or loss of cell delineation alone gives 3'b010. No counted defect gives 3'b000.
- R7: With uneqRdiDis high, the unequipped alarm is not a counted defect for rdiCode in either convention.
- R8: At each strobe, aisReq is loaded with: loss of pointer, OR AU-AIS, OR (trace mismatch when uneqAisDis is high, else unequipped).
- R9: Trace mismatch always counts as a connectivity defect for rdiCode. It feeds aisReq only when uneqAisDis is high. Unequipped feeds aisReq only when uneqAisDis is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe at each frame boundary |
| lopAlm | input | 1 | Loss of pointer alarm |
| aisAlm | input | 1 | Incoming AU-AIS alarm |
| timAlm | input | 1 | Trace identifier mismatch alarm |
| slmAlm | input | 1 | Signal label mismatch alarm |
| uneqAlm | input | 1 | Unequipped alarm (signal label all zeros) |
| lcdAlm | input | 1 | Loss of cell delineation alarm |
| enhancedMode | input | 1 | 1 = class-based coding, 0 = single-bit coding |
| uneqRdiDis | input | 1 | 1 = unequipped does not count toward RDI |
| uneqAisDis | input | 1 | 1 = unequipped does not feed AIS; trace mismatch does |
| rdiCode | output | 3 | Code for transmit status bits 3 to 1 |
| aisReq | output | 1 | Downstream AIS insertion request |

## Verification
Defects of different classes can be active at the same strobe. In that cycle the priority between server, connectivity and payload codes must settle on one value. The unequipped and trace-mismatch alarms can also be active together while the two disable bits send them to different outputs. Random stimulus sets every alarm and configuration bit independently on each cycle, so these overlaps arise often. Directed cases force the all-alarms case and the unequipped-only case under each disable setting. Each cycle's result is compared with a bench function that holds its value between strobes.

// File: rtl/path_rdi_pkg.sv
package path_rdi_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_NONE   = 3'b000;
  localparam logic [CODE_W-1:0] CODE_LEGACY = 3'b100;
  localparam logic [CODE_W-1:0] CODE_SRV    = 3'b101;
  localparam logic [CODE_W-1:0] CODE_CON    = 3'b110;
  localparam logic [CODE_W-1:0] CODE_PAY    = 3'b010;

  typedef struct packed {
    logic load;
    logic srvHit;
    logic conHit;
    logic payHit;
    logic aisHit;
  } rdiStrobe_t;
endpackage

// File: rtl/rdi_ctrl.sv
module rdi_ctrl
  import path_rdi_pkg::*;
(
  input  logic       frameStart,
  input  logic       lopAlm,
  input  logic       aisAlm,
  input  logic       timAlm,
  input  logic       slmAlm,
  input  logic       uneqAlm,
  input  logic       lcdAlm,
  input  logic       uneqRdiDis,
  input  logic       uneqAisDis,
  output rdiStrobe_t strb
);
  logic uneqForRdi;
  logic aisExtra;

  always_comb begin
    uneqForRdi  = uneqAlm & ~uneqRdiDis;
    // supervisory unequipped: trace mismatch takes over the AIS contribution
    aisExtra    = uneqAisDis ? timAlm : uneqAlm;
    strb.load   = frameStart;
    strb.srvHit = lopAlm | aisAlm;
    strb.conHit = timAlm | uneqForRdi;
    strb.payHit = slmAlm | lcdAlm;
    strb.aisHit = lopAlm | aisAlm | aisExtra;
  end
endmodule

// File: rtl/rdi_dp.sv
module rdi_dp
  import path_rdi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enhancedMode,
  input  rdiStrobe_t        strb,
  output logic [CODE_W-1:0] rdiCode,
  output logic              aisReq
);
  logic [CODE_W-1:0] nextCode;

  always_comb begin
    if (!enhancedMode) begin
      nextCode = (strb.srvHit | strb.conHit | strb.payHit) ? CODE_LEGACY : CODE_NONE;
    end else if (strb.srvHit) begin
      nextCode = CODE_SRV;
    end else if (strb.conHit) begin
      nextCode = CODE_CON;
    end else if (strb.payHit) begin
      nextCode = CODE_PAY;
    end else begin
      nextCode = CODE_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdiCode <= CODE_NONE;
      aisReq  <= 1'b0;
    end else if (strb.load) begin
      rdiCode <= nextCode;
      aisReq  <= strb.aisHit;
    end
  end
endmodule

// File: rtl/path_rdi_gen.sv
module path_rdi_gen
  import path_rdi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lopAlm,
  input  logic              aisAlm,
  input  logic              timAlm,
  input  logic              slmAlm,
  input  logic              uneqAlm,
  input  logic              lcdAlm,
  input  logic              enhancedMode,
  input  logic              uneqRdiDis,
  input  logic              uneqAisDis,
  output logic [CODE_W-1:0] rdiCode,
  output logic              aisReq
);
  rdiStrobe_t strb;

  rdi_ctrl u_ctrl (
    .frameStart(frameStart), .lopAlm(lopAlm), .aisAlm(aisAlm),
    .timAlm(timAlm), .slmAlm(slmAlm), .uneqAlm(uneqAlm), .lcdAlm(lcdAlm),
    .uneqRdiDis(uneqRdiDis), .uneqAisDis(uneqAisDis), .strb(strb)
  );

  rdi_dp u_dp (
    .clk(clk), .rstN(rstN), .enhancedMode(enhancedMode), .strb(strb),
    .rdiCode(rdiCode), .aisReq(aisReq)
  );
endmodule

// File: rtl/path_rdi_gen_chk.sv
module path_rdi_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameStart,
  input logic       lopAlm,
  input logic       aisAlm,
  input logic       timAlm,
  input logic       slmAlm,
  input logic       uneqAlm,
  input logic       lcdAlm,
  input logic       enhancedMode,
  input logic       uneqRdiDis,
  input logic       uneqAisDis,
  input logic [2:0] rdiCode,
  input logic       aisReq
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (rdiCode == 3'b000 && !aisReq));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(rdiCode) && $stable(aisReq)));

  a_r3_legacy_values: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !enhancedMode) |=> (rdiCode == 3'b100 || rdiCode == 3'b000));

  a_r4_server_wins: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && enhancedMode && (lopAlm || aisAlm)) |=> rdiCode == 3'b101);

  a_r6_payload_only: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && enhancedMode && slmAlm && !lopAlm && !aisAlm && !timAlm && !uneqAlm)
      |=> rdiCode == 3'b010);

  a_r7_uneq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && uneqRdiDis && !lopAlm && !aisAlm && !timAlm && !slmAlm && !lcdAlm)
      |=> rdiCode == 3'b000);

  a_r8_server_ais: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (lopAlm || aisAlm)) |=> aisReq);

  a_r9_tim_counts: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && timAlm) |=> rdiCode != 3'b000);
endmodule

bind path_rdi_gen path_rdi_gen_chk u_chk (.*);

// File: tb/path_rdi_gen_bench.sv
`timescale 1ns/1ps
module path_rdi_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic lopAlm = 1'b0, aisAlm = 1'b0, timAlm = 1'b0, slmAlm = 1'b0, uneqAlm = 1'b0, lcdAlm = 1'b0;
  logic enhancedMode = 1'b0, uneqRdiDis = 1'b0, uneqAisDis = 1'b0;
  logic [2:0] rdiCode;
  logic aisReq;

  int total = 0;
  int bad = 0;
  logic [2:0] expCode = 3'b000;
  logic expAis = 1'b0;

  always #2 clk = ~clk;

  path_rdi_gen u_path_rdi_gen (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .lopAlm(lopAlm), .aisAlm(aisAlm), .timAlm(timAlm), .slmAlm(slmAlm),
    .uneqAlm(uneqAlm), .lcdAlm(lcdAlm), .enhancedMode(enhancedMode),
    .uneqRdiDis(uneqRdiDis), .uneqAisDis(uneqAisDis),
    .rdiCode(rdiCode), .aisReq(aisReq)
  );

  function automatic logic [2:0] modelCode();
    logic srv, con, pay;
    srv = lopAlm | aisAlm;
    con = timAlm | (uneqAlm & ~uneqRdiDis);
    pay = slmAlm | lcdAlm;
    if (!enhancedMode) return (srv | con | pay) ? 3'b100 : 3'b000;
    if (srv) return 3'b101;
    if (con) return 3'b110;
    if (pay) return 3'b010;
    return 3'b000;
  endfunction

  function automatic logic modelAis();
    return lopAlm | aisAlm | (uneqAisDis ? timAlm : uneqAlm);
  endfunction

  function automatic string codeTag();
    if (!frameStart) return "R2";
    if (uneqAlm && uneqRdiDis) return "R7";
    if (!enhancedMode) return "R3";
    if (lopAlm | aisAlm) return "R4";
    if (timAlm | uneqAlm) return "R5";
    return "R6";
  endfunction

  task automatic checkBoth(input string tag, input string aisTag);
    total++;
    if (rdiCode !== expCode) begin
      bad++;
      $display("FAIL %s rdiCode actual=%b expected=%b", tag, rdiCode, expCode);
    end
    total++;
    if (aisReq !== expAis) begin
      bad++;
      $display("FAIL %s aisReq actual=%b expected=%b", aisTag, aisReq, expAis);
    end
  endtask

  // apply inputs at negedge, clock one edge, sample at next negedge
  task automatic stepCheck();
    string tag, aisTag;
    tag = codeTag();
    aisTag = !frameStart ? "R2" : ((timAlm | uneqAlm) ? "R9" : "R8");
    if (frameStart) begin
      expCode = modelCode();
      expAis  = modelAis();
    end
    @(posedge clk);
    @(negedge clk);
    checkBoth(tag, aisTag);
  endtask

  task automatic setAlarms(input logic [5:0] a);
    {lopAlm, aisAlm, timAlm, slmAlm, uneqAlm, lcdAlm} = a;
  endtask

  initial begin
    #4_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    setAlarms(6'b111111);
    frameStart = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds outputs clear even with alarms and strobe present
    checkBoth("R1", "R1");
    rstN = 1'b1;
    frameStart = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkBoth("R1", "R1");

    // R4: all alarms, enhanced -> server code
    enhancedMode = 1'b1; frameStart = 1'b1; setAlarms(6'b111111);
    stepCheck();
    // R2: alarms gone but no strobe -> hold
    frameStart = 1'b0; setAlarms(6'b000000);
    stepCheck();
    // R5: trace mismatch plus payload
    frameStart = 1'b1; setAlarms(6'b001101);
    stepCheck();
    // R6: payload only
    setAlarms(6'b000001);
    stepCheck();
    // R7: unequipped alone, masked for RDI, still feeds AIS (R9)
    uneqRdiDis = 1'b1; uneqAisDis = 1'b0; setAlarms(6'b000010);
    stepCheck();
    // R9: unequipped alone, AIS path switched to trace mismatch
    uneqAisDis = 1'b1;
    stepCheck();
    // R9: trace mismatch alone feeds AIS now
    setAlarms(6'b001000);
    stepCheck();
    // R3: single-bit coding, payload defect then clear
    enhancedMode = 1'b0; uneqRdiDis = 1'b0; uneqAisDis = 1'b0; setAlarms(6'b000100);
    stepCheck();
    setAlarms(6'b000000);
    stepCheck();
    // R7 in single-bit coding
    uneqRdiDis = 1'b1; setAlarms(6'b000010);
    stepCheck();

    for (int i = 0; i < 3000; i++) begin
      frameStart   = ($urandom % 3) == 0;
      enhancedMode = $urandom % 2;
      uneqRdiDis   = $urandom % 2;
      uneqAisDis   = $urandom % 2;
      for (int b = 0; b < 6; b++) begin
        logic bitv;
        bitv = ($urandom % 4) == 0;
        case (b)
          0: lopAlm = bitv;
          1: aisAlm = bitv;
          2: timAlm = bitv;
          3: slmAlm = bitv;
          4: uneqAlm = bitv;
          default: lcdAlm = bitv;
        endcase
      end
      stepCheck();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule